// File: doc/BRIEF.md
# Ethernet Receive Frame Validator

This block sits on a byte-wide receive stream that begins with the first destination-address byte, right after the start-of-frame delimiter. For every frame it runs a CRC-32 check over every byte, including pad and FCS. It also counts bytes to decide whether the frame survived the 64-byte collision window. When pad stripping is enabled, it reads the 16-bit length field to decide which bytes reach the host side. Frames that are too short, or that collide inside the collision window, vanish with no trace at the output. Every other frame is delivered byte by byte and closed by a status beat that carries the CRC-error and late-collision flags.

Received bytes go into a small FIFO and stay invisible to the reader until the frame can no longer be silently discarded. That point is reached when the 64th byte arrives, or at the end of the frame when short frames are accepted. A discard rewinds the write pointer to the frame's first entry. In strip mode, when the frame has a type value rather than a length, the last four written bytes stay hidden until the frame ends; those four are then withdrawn as the FCS.

The controller has three states. S_IDLE waits for the first byte. S_RECV accepts bytes. S_DROP ignores bytes after an early collision until the last one. The transitions are:
- S_IDLE to S_RECV on a first byte that is not also last and has no early collision.
- S_IDLE to S_DROP on a first byte that carries an early collision.
- S_RECV to S_IDLE on the last byte.
- S_RECV to S_DROP on an early collision before the last byte.
- S_DROP to S_IDLE on the last byte.
- Any state stays where it is otherwise. A one-byte frame returns straight to S_IDLE.

Top module: `rxv_frame_validator`

## Requirements
- R1: After reset `out_valid` is low and stays low until a frame has been accepted.
- R2: With `cfg_strip` low, an accepted frame appears on the output as every received byte in arrival order, FCS included, followed by one status beat with `out_end`=1 and `out_data`=0.
- R3: A frame of fewer than 64 bytes (counting from the first address byte through the last FCS byte) produces no output at all when `cfg_runt_ok` is low.
- R4: With `cfg_runt_ok` high, a frame shorter than 64 bytes is delivered like any other frame.
- R5: If `in_col` is high in a cycle where fewer than 64 bytes have been received (counting a byte accepted in that same cycle), the frame produces no output, and its remaining bytes are ignored up to and including the one flagged `in_last`.
- R6: A collision in a cycle where 64 or more bytes have been received, including the cycle carrying the 64th byte, does not discard the frame; its status beat shows `out_late_col`=1.
- R7: The check is a bit-reflected CRC-32, polynomial 0x04C11DB7, preset to all ones, run over every byte with bit 0 first. A correct frame leaves the register at 0xDEBB20E3, which is the bit-reverse of 0xC704DD7B. Any other value sets `out_crc_err` on the status beat, and the frame is still delivered.
- R8: The CRC includes pad bytes even when stripping keeps them from the output, so a corrupted pad byte sets `out_crc_err`.
- R9: With `cfg_strip` high, bytes 12 (most significant) and 13 form the length field L. If L ≤ 1500, only the first 14+L bytes are delivered, which removes pad and FCS.
- R10: With `cfg_strip` high and a field value above 1500, all bytes except the final four are delivered.
- R11: Frames emerge in arrival order. Each status beat immediately follows that frame's last delivered byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receive byte present |
| in_data | input | 8 | Receive byte |
| in_last | input | 1 | Marks the final byte of the frame (last FCS byte) |
| in_col | input | 1 | Collision seen in this cycle |
| cfg_runt_ok | input | 1 | Deliver frames shorter than 64 bytes |
| cfg_strip | input | 1 | Enable length-driven pad and FCS removal |
| out_valid | output | 1 | Output beat present |
| out_data | output | 8 | Delivered byte (0 on a status beat) |
| out_end | output | 1 | This beat is the frame status |
| out_crc_err | output | 1 | Status: CRC mismatch |
| out_late_col | output | 1 | Status: collision after the 64-byte window |

## Verification
The collision-window test and the commit point both fall on the 64th byte. A collision raised with byte 63 (0-based) must therefore be judged late: the frame is released and its status beat is flagged. The same collision raised one byte earlier must make the whole frame vanish. A collision raised together with `in_last` on an accepted short frame pits runt acceptance against collision discard, and the discard must win. Each case is judged by the scoreboard: expected beats are queued from the requirements, and any beat that arrives without a matching entry counts as a failure.

// File: rtl/rxv_pkg.sv
package rxv_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RECV,
        S_DROP
    } rxv_state_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_GOOD_REG  = 32'hDEBB20E3;

    // One byte through the reflected CRC-32, bit 0 first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            r = (r >> 1) ^ ((r[0] ^ b[k]) ? CRC_POLY_REFL : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxv_crc.sv
module rxv_crc
    import rxv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       en,
    input  logic [7:0] data,
    output logic       good
);

    logic [31:0] crc_q;
    logic [31:0] crc_nx;

    always_comb begin
        crc_nx = crc_step(restart ? 32'hFFFF_FFFF : crc_q, data);
        good   = (crc_nx == CRC_GOOD_REG);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  crc_q <= 32'hFFFF_FFFF;
        else if (en) crc_q <= crc_nx;
    end

endmodule

// File: rtl/rxv_fifo.sv
module rxv_fifo #(
    parameter int DEPTH = 128,
    parameter int EW    = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wa_en,
    input  logic [PW-1:0] wa_ptr,
    input  logic [EW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [PW-1:0] wb_ptr,
    input  logic [EW-1:0] wb_data,
    input  logic [PW-1:0] wr_ptr,
    input  logic [PW-1:0] commit_ptr,
    output logic          rd_valid,
    output logic [EW-1:0] rd_data
);

    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] used_w;
    logic [PW-1:0] used_c;

    assign used_w = wr_ptr - rd_ptr;
    assign used_c = commit_ptr - rd_ptr;

    // The status write comes second, so it wins on a shared address.
    always_ff @(posedge clk) begin
        if (wa_en) mem[wa_ptr[AW-1:0]] <= wa_data;
        if (wb_en) mem[wb_ptr[AW-1:0]] <= wb_data;
    end

    // Only entries below the commit pointer are visible to the reader.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (rd_ptr != commit_ptr) begin
            rd_valid <= 1'b1;
            rd_data  <= mem[rd_ptr[AW-1:0]];
            rd_ptr   <= rd_ptr + 1'b1;
        end else begin
            rd_valid <= 1'b0;
        end
    end

    // R11
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_w <= PW'(DEPTH));

    // R11
    read_behind_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_c <= used_w);

endmodule

// File: rtl/rxv_ctrl.sv
module rxv_ctrl
    import rxv_pkg::*;
#(
    parameter int DEPTH      = 128,
    parameter int SLOT_BYTES = 64,
    parameter int HDR_BYTES  = 14,
    parameter int MAX_LEN    = 1500,
    parameter int FCS_BYTES  = 4,
    parameter int LW         = 16,
    localparam int PW        = $clog2(DEPTH) + 1,
    localparam int EW        = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          in_col,
    input  logic          cfg_runt_ok,
    input  logic          cfg_strip,
    input  logic          crc_good,
    output logic          crc_restart,
    output logic          crc_en,
    output logic          wa_en,
    output logic [PW-1:0] wa_ptr,
    output logic [EW-1:0] wa_data,
    output logic          wb_en,
    output logic [PW-1:0] wb_ptr,
    output logic [EW-1:0] wb_data,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] commit_ptr
);

    localparam logic [LW-1:0] SLOT = LW'(SLOT_BYTES);
    localparam logic [LW-1:0] HDR  = LW'(HDR_BYTES);
    localparam logic [LW-1:0] MAXL = LW'(MAX_LEN);
    localparam logic [PW-1:0] FCSN = PW'(FCS_BYTES);

    rxv_state_e    state_q, state_d;
    logic [LW-1:0] cnt_q, cnt_d;
    logic [LW-1:0] len_q, len_d;
    logic [PW-1:0] wr_q, wr_d;
    logic [PW-1:0] start_q, start_d;
    logic [PW-1:0] commit_q, commit_d;
    logic          late_q, late_d;

    logic          in_frame, take, frame_end, keep_end;
    logic          early_col, late_hit, late_base;
    logic          len_frame, hold, wr_byte;
    logic [LW-1:0] idx, cnt_now;
    logic [PW-1:0] start_now, wr_after, written, pull, stat_ptr;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            cnt_q    <= '0;
            len_q    <= '0;
            wr_q     <= '0;
            start_q  <= '0;
            commit_q <= '0;
            late_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            len_q    <= len_d;
            wr_q     <= wr_d;
            start_q  <= start_d;
            commit_q <= commit_d;
            late_q   <= late_d;
        end
    end

    // Frame-position decode
    always_comb begin
        in_frame  = (state_q == S_RECV) || (state_q == S_IDLE && in_valid);
        take      = in_valid && in_frame;
        frame_end = take && in_last;
        idx       = (state_q == S_IDLE) ? '0 : cnt_q;
        cnt_now   = idx + LW'(in_valid);
        start_now = (state_q == S_IDLE) ? wr_q : start_q;
        late_base = (state_q == S_IDLE) ? 1'b0 : late_q;
        early_col = in_col && in_frame && (cnt_now <  SLOT);
        late_hit  = in_col && in_frame && (cnt_now >= SLOT);
        len_frame = (idx >= HDR) && (len_q <= MAXL);
        hold      = cfg_strip && !len_frame;
        wr_byte   = take && !early_col &&
                    (!cfg_strip || !len_frame || (idx < HDR + len_q));
        wr_after  = wr_q + PW'(wr_byte);
        written   = wr_after - start_now;
        pull      = (hold && frame_end) ? ((written > FCSN) ? FCSN : written) : '0;
        stat_ptr  = wr_after - pull;
        keep_end  = frame_end && !early_col && ((cnt_now >= SLOT) || cfg_runt_ok);
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (in_valid && !in_last) state_d = early_col ? S_DROP : S_RECV;
            end
            S_RECV: begin
                if (frame_end)      state_d = S_IDLE;
                else if (early_col) state_d = S_DROP;
            end
            S_DROP: begin
                if (in_valid && in_last) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Datapath updates and outputs
    always_comb begin
        wr_d     = wr_q;
        commit_d = commit_q;
        start_d  = start_now;
        len_d    = len_q;
        if (early_col || (frame_end && !keep_end)) begin
            wr_d = start_now;
        end else if (keep_end) begin
            wr_d     = stat_ptr + 1'b1;
            commit_d = stat_ptr + 1'b1;
        end else if (take) begin
            wr_d = wr_after;
            if (cnt_now >= SLOT) commit_d = hold ? (wr_after - FCSN) : wr_after;
        end
        if (take && idx == HDR - 2) len_d[LW-1:8] = in_data;
        if (take && idx == HDR - 1) len_d[7:0]    = in_data;
        cnt_d  = (state_d == S_RECV) ? cnt_now : '0;
        late_d = (state_d == S_RECV) ? (late_base || late_hit) : 1'b0;

        crc_restart = (state_q == S_IDLE);
        crc_en      = in_valid && (state_q != S_DROP);
        wa_en       = wr_byte;
        wa_ptr      = wr_q;
        wa_data     = {1'b0, in_data};
        wb_en       = keep_end;
        wb_ptr      = stat_ptr;
        wb_data     = {1'b1, 6'b0, late_base || late_hit, !crc_good};
        wr_ptr      = wr_q;
        commit_ptr  = commit_q;
    end

    // R5
    early_col_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_col |=> (wr_q == commit_q));

    // R3
    runt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RECV && cnt_q < SLOT - 1 && !cfg_runt_ok) |=> $stable(commit_q));

    // R5
    drop_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DROP) |-> !wb_en && !wa_en);

    // R11
    status_closes_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (commit_q == wr_q) && (state_q == S_IDLE));

endmodule

// File: rtl/rxv_frame_validator.sv
module rxv_frame_validator #(
    parameter int DEPTH      = 128,
    parameter int SLOT_BYTES = 64,
    parameter int HDR_BYTES  = 14,
    parameter int MAX_LEN    = 1500,
    parameter int FCS_BYTES  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_col,
    input  logic       cfg_runt_ok,
    input  logic       cfg_strip,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_end,
    output logic       out_crc_err,
    output logic       out_late_col
);

    localparam int PW = $clog2(DEPTH) + 1;
    localparam int EW = 9;

    logic          crc_restart, crc_en, crc_good;
    logic          wa_en, wb_en, rd_valid;
    logic [PW-1:0] wa_ptr, wb_ptr, wr_ptr, commit_ptr;
    logic [EW-1:0] wa_data, wb_data, rd_data;

    rxv_crc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (crc_restart),
        .en      (crc_en),
        .data    (in_data),
        .good    (crc_good)
    );

    rxv_ctrl #(
        .DEPTH      (DEPTH),
        .SLOT_BYTES (SLOT_BYTES),
        .HDR_BYTES  (HDR_BYTES),
        .MAX_LEN    (MAX_LEN),
        .FCS_BYTES  (FCS_BYTES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_last     (in_last),
        .in_col      (in_col),
        .cfg_runt_ok (cfg_runt_ok),
        .cfg_strip   (cfg_strip),
        .crc_good    (crc_good),
        .crc_restart (crc_restart),
        .crc_en      (crc_en),
        .wa_en       (wa_en),
        .wa_ptr      (wa_ptr),
        .wa_data     (wa_data),
        .wb_en       (wb_en),
        .wb_ptr      (wb_ptr),
        .wb_data     (wb_data),
        .wr_ptr      (wr_ptr),
        .commit_ptr  (commit_ptr)
    );

    rxv_fifo #(
        .DEPTH (DEPTH),
        .EW    (EW)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wa_en      (wa_en),
        .wa_ptr     (wa_ptr),
        .wa_data    (wa_data),
        .wb_en      (wb_en),
        .wb_ptr     (wb_ptr),
        .wb_data    (wb_data),
        .wr_ptr     (wr_ptr),
        .commit_ptr (commit_ptr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    always_comb begin
        out_valid    = rd_valid;
        out_end      = rd_valid && rd_data[8];
        out_data     = rd_data[8] ? 8'h00 : rd_data[7:0];
        out_crc_err  = out_end && rd_data[0];
        out_late_col = out_end && rd_data[1];
    end

endmodule

// File: tb/tb_rxv_frame_validator.sv
module tb_rxv_frame_validator;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_last = 1'b0, in_col = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       cfg_runt_ok = 1'b0, cfg_strip = 1'b0;
    logic       out_valid, out_end, out_crc_err, out_late_col;
    logic [7:0] out_data;

    always #4 clk = ~clk;

    rxv_frame_validator dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_col(in_col), .cfg_runt_ok(cfg_runt_ok),
        .cfg_strip(cfg_strip), .out_valid(out_valid), .out_data(out_data),
        .out_end(out_end), .out_crc_err(out_crc_err), .out_late_col(out_late_col)
    );

    logic [7:0]  fr [0:1599];
    int          fr_n;
    logic [10:0] sb_q[$];
    string       sb_tag[$];
    int          checks = 0, fails = 0, beats = 0;
    bit          done = 1'b0;

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
        for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = c[0] ^ b[k];
            c = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c;
    endfunction

    task automatic build(input int lenf, input int nbody, input int seed);
        logic [31:0] c;
        for (int i = 0; i < 12; i++) fr[i] = 8'(8'h20 + i * 3 + seed);
        fr[12] = 8'(lenf >> 8);
        fr[13] = 8'(lenf);
        for (int i = 0; i < nbody; i++) fr[14 + i] = 8'(seed * 5 + i * 7 + 1);
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 14 + nbody; i++) c = ref_crc(c, fr[i]);
        c = ~c;
        for (int i = 0; i < 4; i++) fr[14 + nbody + i] = c[8*i +: 8];
        fr_n = 18 + nbody;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Driver: queues the expected beats, then plays the frame in.
    task automatic send(input string req, input int col_at, input bit bad,
                        input bit runt_ok, input bit strip);
        int  fwd, lenf;
        bit  keep;
        bit  late;
        late = (col_at >= 63);
        keep = !(col_at >= 0 && col_at < 63) && (fr_n >= 64 || runt_ok);
        lenf = fr[12] * 256 + fr[13];
        if (!strip)                       fwd = fr_n;
        else if (fr_n >= 14 && lenf <= 1500) fwd = (14 + lenf < fr_n) ? 14 + lenf : fr_n;
        else                              fwd = (fr_n >= 4) ? fr_n - 4 : 0;
        if (keep) begin
            for (int i = 0; i < fwd; i++) begin
                sb_q.push_back({3'b000, fr[i]});
                sb_tag.push_back(req);
            end
            sb_q.push_back({1'b1, bad, late, 8'h00});
            sb_tag.push_back(req);
        end
        @(negedge clk);
        cfg_runt_ok = runt_ok;
        cfg_strip   = strip;
        for (int i = 0; i < fr_n; i++) begin
            in_valid = 1'b1;
            in_data  = fr[i];
            in_last  = (i == fr_n - 1);
            in_col   = (i == col_at);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_col   = 1'b0;
    endtask

    task automatic drain(input string req);
        int b0;
        b0 = beats;
        repeat (200) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d expected beats missing (actual %0d beats, expected 0 left)",
                     req, sb_q.size(), beats - b0);
            sb_q.delete();
            sb_tag.delete();
        end
    endtask

    // Monitor: pops and compares every produced beat.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            logic [10:0] got, exp;
            string       t;
            beats++;
            got = {out_end, out_crc_err, out_late_col, out_data};
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL R3/R5: unexpected beat actual %h expected none", got);
            end else begin
                exp = sb_q.pop_front();
                t   = sb_tag.pop_front();
                if (got !== exp) begin
                    fails++;
                    $display("FAIL %s: beat actual %h expected %h", t, got, exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        // R1: quiet after reset
        checks++;
        if (out_valid !== 1'b0 || beats != 0) begin
            fails++;
            $display("FAIL R1: out_valid actual %b expected 0", out_valid);
        end

        // R2: plain 64-byte frame, all bytes plus status
        build(46, 46, 1);  send("R2", -1, 0, 0, 0);  drain("R2");
        // R7: corrupted FCS byte, delivered with CRC error
        build(46, 46, 2);  fr[fr_n-2] = fr[fr_n-2] ^ 8'h10;  send("R7", -1, 1, 0, 0);  drain("R7");
        // R3: 38-byte runt vanishes
        build(20, 20, 3);  send("R3", -1, 0, 0, 0);  drain("R3");
        // R4: same size runt accepted
        build(20, 20, 4);  send("R4", -1, 0, 1, 0);  drain("R4");
        // R5: collision at byte 20
        build(82, 82, 5);  send("R5", 20, 0, 0, 0);  drain("R5");
        // R5: collision with byte 62 (63 bytes seen) still early
        build(82, 82, 6);  send("R5", 62, 0, 0, 0);  drain("R5");
        // R6: collision with byte 63 (64th byte) is late
        build(82, 82, 7);  send("R6", 63, 0, 0, 0);  drain("R6");
        // R6: collision well past the window
        build(82, 82, 8);  send("R6", 80, 0, 0, 0);  drain("R6");
        // R9: length 20 with pad, strip keeps 34 bytes
        build(20, 46, 9);  send("R9", -1, 0, 0, 1);  drain("R9");
        // R9: length 100, strip drops only the FCS
        build(100, 100, 10);  send("R9", -1, 0, 0, 1);  drain("R9");
        // R10: type value 0x0800, strip drops last four
        build(16'h0800, 60, 11);  send("R10", -1, 0, 0, 1);  drain("R10");
        // R8: corrupted pad byte still flagged
        build(20, 46, 12);  fr[40] = fr[40] ^ 8'h01;  send("R8", -1, 1, 0, 1);  drain("R8");
        // R5: collision together with last byte on an accepted runt
        build(20, 20, 13);  send("R5", 37, 0, 1, 0);  drain("R5");
        // R11: back-to-back frames keep order
        build(46, 46, 14);  send("R11", -1, 0, 0, 0);
        build(16'h0806, 50, 15);  send("R11", -1, 0, 0, 1);
        drain("R11");
        finish_run();
    end

endmodule